// File: doc/BRIEF.md
# Flash Operation Status and Ready/Busy Unit

This unit sits beside the erase, program and read-first-access sequencers of a flash operation engine. It tracks whether an operation is in progress and drives an active-low ready/busy line. It also keeps a status byte that the host polls, and it tells the command decoder whether the command byte it currently presents may be taken. The sequencers report three kinds of event: an operation start (with its kind), a completion, and a completion with failure.

Erase and program failures are latched into two separate sticky bits. Each one stays set until the host sends a clear opcode, sends the reset opcode, or pulses the chip-select release, and none of these clears is honoured while busy. While either bit is set, new erase or program work is refused, but a read first-access may still run. Each kind of operation also has a watchdog limit, given as a parameter in clock cycles. An operation that reaches its limit without completing is ended and, for erase or program, recorded as a failure.

The FSM has four states: READY, ERASING, PROGRAMMING and FIRST_ACCESS. The transitions are:
- READY to ERASING, PROGRAMMING or FIRST_ACCESS on an accepted start.
- Any busy state back to READY on a done event, which is called FINISH.
- Any busy state back to READY when its limit count is reached, which is called EXPIRE.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte reads 80h, `busy_n` is 1 and `cmd_accept` is 1, and both failure bits are 0.
- R2: Status byte layout: bit 7 is 1 in READY and 0 in any busy state, bit 5 is the erase-failure flag, bit 4 is the program-failure flag, and bits 6 and 3..0 always read 0.
- R3: A start pulse sent in READY is taken according to `start_kind`: 0 selects erase, 1 selects program and 2 selects read first-access, while 3 is ignored. From the next cycle a taken start drives `busy_n` and status bit 7 to 0.
- R4: `done_valid` while busy returns the unit to READY in the next cycle. With `done_fail` it sets bit 5 after an erase or bit 4 after a program, and it sets no bit after a read first-access. `done_valid` in READY has no effect.
- R5: If no done arrives, an erase, program or read leaves busy after exactly ERASE_TIMEOUT, PROGRAM_TIMEOUT or READ_TIMEOUT cycles respectively, counted from the start edge. An erase or program that ends this way sets its failure bit. A done presented in the last permitted cycle takes priority over the expiry.
- R6: The failure bits are sticky and survive later operations, such as a read first-access, until they are cleared.
- R7: In READY, any of the following clears both failure bits on the next edge: `cmd_valid` with code 50h, `cmd_valid` with code FFh, or `cs_release`. While busy, all three are ignored.
- R8: While either failure bit is set, an erase or program start is ignored and the unit stays in READY. A read start is still taken.
- R9: `cmd_accept` is 0 while busy. It is also 0 when a failure bit is set and `cmd_code` is one of 20h, 10h, 11h, 1Fh, 0Fh or 12h. In every other case it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe from the decoder |
| cmd_code | input | 8 | Command byte being presented |
| cs_release | input | 1 | Chip-select release pulse (acts as a clear) |
| start_valid | input | 1 | Operation start pulse from a sequencer |
| start_kind | input | 2 | 0 erase, 1 program, 2 read first-access, 3 unused |
| done_valid | input | 1 | Operation completion pulse |
| done_fail | input | 1 | Completion carries a failure (with done_valid) |
| status_byte | output | 8 | Polled status byte |
| busy_n | output | 1 | Ready/busy line, 0 while busy |
| cmd_accept | output | 1 | Presented command may be taken |

## Verification
The collision of interest is a done event arriving in the same cycle that the watchdog count reaches its limit, since both try to end the operation. The bench starts an erase, idles for exactly one cycle less than the limit, and then presents a passing done on the final permitted cycle. It judges the result by requiring READY with the erase-failure bit still clear. Separate runs let each limit expire on its own, and the bench checks that the unit stays busy on every cycle before the expiry.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    typedef enum logic [1:0] {
        ST_READY        = 2'd0,
        ST_ERASING      = 2'd1,
        ST_PROGRAMMING  = 2'd2,
        ST_FIRST_ACCESS = 2'd3
    } fstat_state_t;

    localparam logic [1:0] KIND_ERASE   = 2'd0;
    localparam logic [1:0] KIND_PROGRAM = 2'd1;
    localparam logic [1:0] KIND_READ    = 2'd2;

    localparam logic [7:0] OPC_CLEAR = 8'h50;
    localparam logic [7:0] OPC_RESET = 8'hFF;

    // Opcodes that open an erase or program sequence
    function automatic logic opc_modifies(input logic [7:0] code);
        return (code == 8'h20) || (code == 8'h10) || (code == 8'h11) ||
               (code == 8'h1F) || (code == 8'h0F) || (code == 8'h12);
    endfunction

endpackage

// File: rtl/fstat_timer.sv
module fstat_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt_q;

    assign at_limit = run && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (run && !at_limit)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit)); // R5

endmodule

// File: rtl/fstat_flags.sv
module fstat_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_erase,
    input  logic set_program,
    output logic erase_fail,
    output logic program_fail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_fail   <= 1'b0;
            program_fail <= 1'b0;
        end else begin
            if (set_erase)
                erase_fail <= 1'b1;
            else if (clr)
                erase_fail <= 1'b0;
            if (set_program)
                program_fail <= 1'b1;
            else if (clr)
                program_fail <= 1'b0;
        end
    end

    AST_ERASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_fail) |-> $past(clr)); // R6

    AST_PROGRAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(program_fail) |-> $past(clr)); // R6

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fstat_pkg::*;
#(
    parameter int ERASE_TIMEOUT   = 300000,
    parameter int PROGRAM_TIMEOUT = 600000,
    parameter int READ_TIMEOUT    = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       cs_release,
    input  logic       start_valid,
    input  logic [1:0] start_kind,
    input  logic       done_valid,
    input  logic       done_fail,
    output logic [7:0] status_byte,
    output logic       busy_n,
    output logic       cmd_accept
);
    localparam int MAX_EP = (ERASE_TIMEOUT > PROGRAM_TIMEOUT) ? ERASE_TIMEOUT : PROGRAM_TIMEOUT;
    localparam int MAX_TO = (MAX_EP > READ_TIMEOUT) ? MAX_EP : READ_TIMEOUT;
    localparam int CNT_W  = $clog2(MAX_TO + 1);

    fstat_state_t     state_q, state_d;
    logic             erase_fail, program_fail, err_any;
    logic             start_ok, clear_ok, at_limit;
    logic             set_erase, set_program;
    logic [CNT_W-1:0] limit_sel;

    assign err_any  = erase_fail || program_fail;
    assign start_ok = start_valid && (state_q == ST_READY) &&
                      ((start_kind == KIND_READ) ||
                       (((start_kind == KIND_ERASE) || (start_kind == KIND_PROGRAM)) && !err_any));
    assign clear_ok = (state_q == ST_READY) &&
                      (cs_release || (cmd_valid && ((cmd_code == OPC_CLEAR) || (cmd_code == OPC_RESET))));

    always_comb begin
        unique case (state_q)
            ST_ERASING:     limit_sel = CNT_W'(ERASE_TIMEOUT);
            ST_PROGRAMMING: limit_sel = CNT_W'(PROGRAM_TIMEOUT);
            default:        limit_sel = CNT_W'(READ_TIMEOUT);
        endcase
    end

    // Next-state: START, FINISH and EXPIRE transitions
    always_comb begin
        state_d     = state_q;
        set_erase   = 1'b0;
        set_program = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (start_ok) begin
                    if (start_kind == KIND_ERASE)
                        state_d = ST_ERASING;
                    else if (start_kind == KIND_PROGRAM)
                        state_d = ST_PROGRAMMING;
                    else
                        state_d = ST_FIRST_ACCESS;
                end
            end
            ST_ERASING: begin
                if (done_valid) begin
                    state_d   = ST_READY;
                    set_erase = done_fail;
                end else if (at_limit) begin
                    state_d   = ST_READY;
                    set_erase = 1'b1;
                end
            end
            ST_PROGRAMMING: begin
                if (done_valid) begin
                    state_d     = ST_READY;
                    set_program = done_fail;
                end else if (at_limit) begin
                    state_d     = ST_READY;
                    set_program = 1'b1;
                end
            end
            ST_FIRST_ACCESS: begin
                if (done_valid || at_limit)
                    state_d = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy_n      = (state_q == ST_READY);
        status_byte = {busy_n, 1'b0, erase_fail, program_fail, 4'b0000};
        cmd_accept  = busy_n && !(err_any && opc_modifies(cmd_code));
    end

    fstat_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_READY),
        .restart  (start_ok),
        .limit    (limit_sel),
        .at_limit (at_limit)
    );

    fstat_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clear_ok),
        .set_erase    (set_erase),
        .set_program  (set_program),
        .erase_fail   (erase_fail),
        .program_fail (program_fail)
    );

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> !cmd_accept); // R9

    AST_ERROR_BLOCKS_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && start_valid && (start_kind != KIND_READ) && (status_byte[5] || status_byte[4]))
        |=> busy_n); // R8

    AST_READ_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && start_valid && (start_kind == KIND_READ)) |=> !busy_n); // R3

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && done_valid) |=> busy_n); // R4

    AST_CLEAR_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && cs_release) |=> (status_byte[5:4] == 2'b00)); // R7

endmodule

// File: tb/sim_flash_status_unit.sv
module sim_flash_status_unit;
    import fstat_pkg::*;

    localparam int ET = 6;
    localparam int PT = 8;
    localparam int RT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       cs_release = 1'b0;
    logic       start_valid = 1'b0;
    logic [1:0] start_kind = 2'd0;
    logic       done_valid = 1'b0;
    logic       done_fail = 1'b0;
    logic [7:0] status_byte;
    logic       busy_n;
    logic       cmd_accept;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_status_unit #(
        .ERASE_TIMEOUT(ET), .PROGRAM_TIMEOUT(PT), .READ_TIMEOUT(RT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cs_release(cs_release), .start_valid(start_valid), .start_kind(start_kind),
        .done_valid(done_valid), .done_fail(done_fail), .status_byte(status_byte),
        .busy_n(busy_n), .cmd_accept(cmd_accept)
    );

    typedef struct packed {
        logic       sv;
        logic [1:0] kind;
        logic       dv;
        logic       df;
        logic       cv;
        logic [7:0] code;
        logic       csr;
        logic       acc;   // expected cmd_accept before the edge
        logic [7:0] st;    // expected status after the edge
        logic       bn;    // expected busy_n after the edge
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h80, 1'b1, 4'd1}, // R1 idle
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3}, // R3 erase
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9}, // R9 busy
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1, 4'd4}, // R4 pass
        '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3}, // R3 program
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h90, 1'b1, 4'd2}, // R2 bit4
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, 8'h90, 1'b1, 4'd9}, // R9 20h
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h90, 1'b0, 1'b1, 8'h90, 1'b1, 4'd9}, // R9 90h
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h90, 1'b1, 4'd8}, // R8 blocked
        '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0, 4'd8}, // R8 read ok
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h50, 1'b0, 1'b0, 8'h10, 1'b0, 4'd7}, // R7 busy clr
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h90, 1'b1, 4'd6}, // R6 sticky
        '{1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h90, 1'b1, 4'd3}, // R3 kind 3
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h90, 1'b1, 4'd4}, // R4 idle done
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h50, 1'b0, 1'b1, 8'h80, 1'b1, 4'd7}, // R7 50h
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3}, // R3 erase
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hA0, 1'b1, 4'd2}, // R2 bit5
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 8'hA0, 1'b1, 4'd9}, // R9 12h
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h80, 1'b1, 4'd7}, // R7 cs
        '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3}, // R3 program
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h90, 1'b1, 4'd4}, // R4 fail
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, 8'h80, 1'b1, 4'd7}, // R7 FFh
        '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3}, // R3 read
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1, 4'd4}  // R4 read fail
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic sv, input logic [1:0] kd, input logic dv, input logic df,
                         input logic cv, input logic [7:0] cd, input logic csr);
        @(negedge clk);
        start_valid = sv; start_kind = kd; done_valid = dv; done_fail = df;
        cmd_valid = cv; cmd_code = cd; cs_release = csr;
    endtask

    task automatic after_edge(input string req, input logic [7:0] st, input logic bn);
        @(posedge clk);
        #1;
        check(req, "status", int'(status_byte), int'(st));
        check(req, "busy_n", int'(busy_n), int'(bn));
    endtask

    task automatic idle(input string req, input logic [7:0] st, input logic bn);
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge(req, st, bn);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "status in reset", int'(status_byte), 8'h80);
        check("R1", "busy_n in reset", int'(busy_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "accept after reset", int'(cmd_accept), 1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sv, VEC[i].kind, VEC[i].dv, VEC[i].df, VEC[i].cv, VEC[i].code, VEC[i].csr);
            #1;
            check($sformatf("R%0d row %0d", VEC[i].req, i), "cmd_accept", int'(cmd_accept), int'(VEC[i].acc));
            after_edge($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].st, VEC[i].bn);
        end

        // R5 erase expiry: busy for ET-1 more cycles, ready on the ET-th
        drive(1'b1, KIND_ERASE, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R5 erase start", 8'h00, 1'b0);
        for (int k = 0; k < ET - 1; k++) idle("R5 erase wait", 8'h00, 1'b0);
        idle("R5 erase expiry", 8'hA0, 1'b1);
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, OPC_CLEAR, 1'b0);
        after_edge("R7 clear", 8'h80, 1'b1);

        // R5 collision: done on the last permitted cycle wins
        drive(1'b1, KIND_ERASE, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R5 collision start", 8'h00, 1'b0);
        for (int k = 0; k < ET - 1; k++) idle("R5 collision wait", 8'h00, 1'b0);
        drive(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R5 done beats expiry", 8'h80, 1'b1);

        // R5 program expiry
        drive(1'b1, KIND_PROGRAM, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R5 program start", 8'h00, 1'b0);
        for (int k = 0; k < PT - 1; k++) idle("R5 program wait", 8'h00, 1'b0);
        idle("R5 program expiry", 8'h90, 1'b1);
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        after_edge("R7 cs clear", 8'h80, 1'b1);

        // R5 read expiry sets no flag
        drive(1'b1, KIND_READ, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R5 read start", 8'h00, 1'b0);
        for (int k = 0; k < RT - 1; k++) idle("R5 read wait", 8'h00, 1'b0);
        idle("R5 read expiry", 8'h80, 1'b1);

        // R1 reset clears a latched failure
        drive(1'b1, KIND_ERASE, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        after_edge("R3 erase", 8'h00, 1'b0);
        drive(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h20, 1'b0);
        after_edge("R4 erase fail", 8'hA0, 1'b1);
        #1;
        check("R9", "accept 20h with error", int'(cmd_accept), 0);
        @(negedge clk);
        done_valid = 1'b0; done_fail = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", "status after reset", int'(status_byte), 8'h80);
        check("R1", "accept 20h after reset", int'(cmd_accept), 1);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 idle after reset", 8'h80, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule